// File: doc/BRIEF.md
# Display Multiplex and Blink Timer

This block produces all scan and blink timing for a multiplexed matrix LED display, from one multiplex clock. The clock is cut into fixed digit slots, each lasting a set number of clock cycles. A scan frame is a fixed number of such slots. The first slots of a frame each enable one digit through a one-hot output, in a fixed rotating order. The slots that remain in the frame are blanking slots, in which no digit is enabled. With the default values a frame is 14 slots of 400 cycles, or 5600 cycles. At a 4 MHz clock each digit is lit for 100 µs.

A frame counter drives a two-phase blink signal. The blink period is a whole number of frames, split equally between phase P0 (blink output high) and phase P1 (blink output low). A rate bit selects a slow or a fast period. The phase only ever changes at a frame boundary. When blink is disabled the phase stays at P0, but the frame counter keeps running.

A small control register takes three bits: blink enable, fast rate and timing restart. It captures them when chip select is deasserted. The restart bit lasts one cycle and brings the scan and blink timers back to the start of digit slot 0 and phase P0. Devices that share a clock and get their chip select released together therefore stay in step.

Top module: `mux_blink_timer`

## Requirements
- R1: After reset, digit_en enables only digit 0 (value 1), blink_out is 1, and cfg_rd reads 0.
- R2: Digits are enabled one at a time in ascending order, digit 0 first. Each one stays enabled for exactly SLOT_CYCLES consecutive cycles.
- R3: A frame lasts SLOT_CYCLES*FRAME_SLOTS cycles. During the last FRAME_SLOTS-NUM_DIGITS slots of a frame, digit_en is 0.
- R4: At most one bit of digit_en is 1 in any cycle.
- R5: blink_out is 1 during phase P0 and 0 during phase P1. cfg_rd bit 3 reads 1 exactly when the phase is P1.
- R6: With blink enabled, the blink period is SLOW_FRAMES frames when cfg_rd bit 1 is 0 and FAST_FRAMES frames when it is 1. The first half of the period is P0 and the second half is P1. If the frame count is past the end of the new period after a rate change, it wraps to 0 at the next frame boundary.
- R7: With blink disabled (cfg_rd bit 0 is 0), the phase becomes P0 at the next frame boundary and stays there. The frame count keeps advancing, so blink picks up its position in the period when it is enabled again.
- R8: The phase changes only on the clock edge that ends a frame, or on a restart.
- R9: The data inputs are captured only on the first clock edge that sees cs_n high after it was low. blink enable is read back in cfg_rd bit 0 and fast rate in cfg_rd bit 1. Data that changes at any other time has no effect.
- R10: A restart bit written as 1 acts one cycle after capture. From the next cycle on, digit 0 begins a full slot and phase P0 begins a full half period. cfg_rd bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplex clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; a rising edge captures the control inputs |
| wr_blink_en | input | 1 | Control data: blink enable |
| wr_fast | input | 1 | Control data: fast blink rate |
| wr_restart | input | 1 | Control data: restart the timing (self-clearing) |
| digit_en | output | NUM_DIGITS | One-hot digit enable |
| blink_out | output | 1 | Blink phase: 1 in P0, 0 in P1 |
| cfg_rd | output | 4 | Readback: [0] blink enable, [1] fast, [2] restart (always 0), [3] phase P1 |

## Verification
The hardest case to reach is a rate switch from slow to fast while the frame count is already past the end of the fast period. Close behind it are a disable or re-enable that falls just before a frame boundary, and a restart that lands mid-period. The bench runs with small slot, frame and period values so that many periods go by quickly. It makes random control writes at random idle gaps, with spurious data toggles while chip select is idle. A cycle-level reference model tracks every slot, frame and phase position, and directed restarts measure exact run lengths of slots and phases.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

   typedef struct packed {
      logic blink_en;
      logic fast;
      logic restart;
   } ctl_t;

   localparam int CFG_W         = 4;
   localparam int CFG_EN_BIT    = 0;
   localparam int CFG_FAST_BIT  = 1;
   localparam int CFG_RST_BIT   = 2;
   localparam int CFG_PHASE_BIT = 3;

   function automatic int width_of(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mbt_ctl_reg.sv
module mbt_ctl_reg
   import mbt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  ctl_t wr,
   output logic blink_en,
   output logic fast,
   output logic restart
);

   logic cs_q;
   logic cs_rise;

   assign cs_rise = cs_n & ~cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         blink_en <= 1'b0;
         fast     <= 1'b0;
         restart  <= 1'b0;
      end else begin
         cs_q <= cs_n;
         if (cs_rise) begin
            blink_en <= wr.blink_en;
            fast     <= wr.fast;
            restart  <= wr.restart;
         end else begin
            restart  <= 1'b0;
         end
      end
   end

   // R10: restart is a single-cycle pulse
   a_r10_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart);

   // R9: a capture only follows a seen low-to-high chip select transition
   a_r9_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> $past(cs_n));

endmodule

// File: rtl/mbt_scan_gen.sv
module mbt_scan_gen
   import mbt_pkg::*;
#(
   parameter int SLOT_CYCLES = 400,
   parameter int FRAME_SLOTS = 14,
   parameter int NUM_DIGITS  = 4,
   parameter bit REVERSE     = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  restart,
   output logic [NUM_DIGITS-1:0] digit_en,
   output logic                  frame_end
);

   localparam int CYC_W  = width_of(SLOT_CYCLES);
   localparam int SLOT_W = width_of(FRAME_SLOTS);
   localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYCLES - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);

   generate
      if (SLOT_CYCLES < 2)
         $error("mbt_scan_gen: SLOT_CYCLES must be at least 2");
      if (FRAME_SLOTS < 2)
         $error("mbt_scan_gen: FRAME_SLOTS must be at least 2");
      if (NUM_DIGITS < 1 || NUM_DIGITS > FRAME_SLOTS)
         $error("mbt_scan_gen: NUM_DIGITS must lie in 1..FRAME_SLOTS");
   endgenerate

   logic [CYC_W-1:0]  cyc_q;
   logic [SLOT_W-1:0] slot_q;
   logic              last_cyc;
   logic              last_slot;

   assign last_cyc  = (cyc_q == CYC_LAST);
   assign last_slot = (slot_q == SLOT_LAST);
   assign frame_end = last_cyc & last_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         slot_q <= '0;
      end else if (restart) begin
         cyc_q  <= '0;
         slot_q <= '0;
      end else if (last_cyc) begin
         cyc_q  <= '0;
         slot_q <= last_slot ? '0 : slot_q + SLOT_W'(1);
      end else begin
         cyc_q  <= cyc_q + CYC_W'(1);
      end
   end

   generate
      for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
         if (REVERSE) begin : g_down
            assign digit_en[g] = (slot_q == SLOT_W'(NUM_DIGITS - 1 - g));
         end else begin : g_up
            assign digit_en[g] = (slot_q == SLOT_W'(g));
         end
      end
   endgenerate

   // R4: never two digits at once
   a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(digit_en));

   // R2: slot index holds until its last cycle
   a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!last_cyc && !restart) |=> $stable(slot_q));

   // R3: frame wraps back to slot 0 cycle 0
   a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !restart) |=> (slot_q == '0 && cyc_q == '0));

   // R10: restart lands on the start of slot 0
   a_r10_scan_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (slot_q == '0 && cyc_q == '0));

endmodule

// File: rtl/mbt_blink_gen.sv
module mbt_blink_gen
   import mbt_pkg::*;
#(
   parameter int SLOW_FRAMES = 256,
   parameter int FAST_FRAMES = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic frame_end,
   input  logic blink_en,
   input  logic fast,
   output logic phase_p1
);

   localparam int MAX_FRAMES = (SLOW_FRAMES > FAST_FRAMES) ? SLOW_FRAMES : FAST_FRAMES;
   localparam int FRM_W      = width_of(MAX_FRAMES) + 1;
   localparam logic [FRM_W-1:0] SLOW_P = FRM_W'(SLOW_FRAMES);
   localparam logic [FRM_W-1:0] FAST_P = FRM_W'(FAST_FRAMES);

   generate
      if (SLOW_FRAMES < 2 || (SLOW_FRAMES % 2) != 0)
         $error("mbt_blink_gen: SLOW_FRAMES must be even and at least 2");
      if (FAST_FRAMES < 2 || (FAST_FRAMES % 2) != 0)
         $error("mbt_blink_gen: FAST_FRAMES must be even and at least 2");
   endgenerate

   logic [FRM_W-1:0] period;
   logic [FRM_W-1:0] half;
   logic [FRM_W-1:0] cnt_q;
   logic [FRM_W-1:0] cnt_nxt;

   assign period  = fast ? FAST_P : SLOW_P;
   assign half    = period >> 1;
   assign cnt_nxt = (cnt_q >= period - FRM_W'(1)) ? '0 : cnt_q + FRM_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         phase_p1 <= 1'b0;
      end else if (restart) begin
         cnt_q    <= '0;
         phase_p1 <= 1'b0;
      end else if (frame_end) begin
         cnt_q    <= cnt_nxt;
         phase_p1 <= blink_en & (cnt_nxt >= half);
      end
   end

   // R8: phase moves only at a frame edge or restart
   a_r8_phase_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && !restart) |=> $stable(phase_p1));

   // R7: disabled blink sits in P0 after the boundary
   a_r7_disabled_p0: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !blink_en) |=> !phase_p1);

   // R10: restart returns to the start of P0
   a_r10_blink_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!phase_p1 && cnt_q == '0));

   // R6: frame count never runs past the longer period
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < FRM_W'(MAX_FRAMES));

endmodule

// File: rtl/mux_blink_timer.sv
module mux_blink_timer
   import mbt_pkg::*;
#(
   parameter int SLOT_CYCLES  = 400,
   parameter int FRAME_SLOTS  = 14,
   parameter int NUM_DIGITS   = 4,
   parameter int SLOW_FRAMES  = 256,
   parameter int FAST_FRAMES  = 128,
   parameter bit REVERSE_SCAN = 1'b0,
   parameter bit P0_HIGH      = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n,
   input  logic                  wr_blink_en,
   input  logic                  wr_fast,
   input  logic                  wr_restart,
   output logic [NUM_DIGITS-1:0] digit_en,
   output logic                  blink_out,
   output logic [CFG_W-1:0]      cfg_rd
);

   ctl_t wr;
   logic en_q;
   logic fast_q;
   logic restart_p;
   logic frame_end;
   logic phase_p1;

   assign wr.blink_en = wr_blink_en;
   assign wr.fast     = wr_fast;
   assign wr.restart  = wr_restart;

   mbt_ctl_reg u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .wr       (wr),
      .blink_en (en_q),
      .fast     (fast_q),
      .restart  (restart_p)
   );

   mbt_scan_gen #(
      .SLOT_CYCLES (SLOT_CYCLES),
      .FRAME_SLOTS (FRAME_SLOTS),
      .NUM_DIGITS  (NUM_DIGITS),
      .REVERSE     (REVERSE_SCAN)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart_p),
      .digit_en  (digit_en),
      .frame_end (frame_end)
   );

   mbt_blink_gen #(
      .SLOW_FRAMES (SLOW_FRAMES),
      .FAST_FRAMES (FAST_FRAMES)
   ) u_blink (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart_p),
      .frame_end (frame_end),
      .blink_en  (en_q),
      .fast      (fast_q),
      .phase_p1  (phase_p1)
   );

   generate
      if (P0_HIGH) begin : g_pol_hi
         assign blink_out = ~phase_p1;
      end else begin : g_pol_lo
         assign blink_out = phase_p1;
      end
   endgenerate

   always_comb begin
      cfg_rd                = '0;
      cfg_rd[CFG_EN_BIT]    = en_q;
      cfg_rd[CFG_FAST_BIT]  = fast_q;
      cfg_rd[CFG_RST_BIT]   = 1'b0;
      cfg_rd[CFG_PHASE_BIT] = phase_p1;
   end

   // R5: pin and status bit always report the same phase
   a_r5_phase_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (blink_out == P0_HIGH) == !cfg_rd[CFG_PHASE_BIT]);

endmodule

// File: tb/mux_blink_timer_tb.sv
module mux_blink_timer_tb;

   localparam int SLOT  = 5;
   localparam int SLOTS = 6;
   localparam int NDIG  = 4;
   localparam int SLOWF = 8;
   localparam int FASTF = 4;
   localparam int FRAME = SLOT * SLOTS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic wr_blink_en = 1'b0;
   logic wr_fast = 1'b0;
   logic wr_restart = 1'b0;
   logic [NDIG-1:0] digit_en;
   logic blink_out;
   logic [3:0] cfg_rd;

   int n_chk = 0;
   int n_err = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mux_blink_timer #(
      .SLOT_CYCLES (SLOT),
      .FRAME_SLOTS (SLOTS),
      .NUM_DIGITS  (NDIG),
      .SLOW_FRAMES (SLOWF),
      .FAST_FRAMES (FASTF)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .wr_blink_en (wr_blink_en),
      .wr_fast     (wr_fast),
      .wr_restart  (wr_restart),
      .digit_en    (digit_en),
      .blink_out   (blink_out),
      .cfg_rd      (cfg_rd)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_digits(input int slot);
      return (slot < NDIG) ? (1 << slot) : 0;
   endfunction

   function automatic int period_of(input bit f);
      return f ? FASTF : SLOWF;
   endfunction

   // Reference model of the required timing
   int  m_cyc, m_slot, m_frm;
   bit  m_csq, m_en, m_fast, m_tr, m_p1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_csq <= 1; m_en <= 0; m_fast <= 0; m_tr <= 0;
         m_cyc <= 0; m_slot <= 0; m_frm <= 0; m_p1 <= 0;
      end else begin
         m_csq <= cs_n;
         if (cs_n && !m_csq) begin
            m_en <= wr_blink_en; m_fast <= wr_fast; m_tr <= wr_restart;
         end else begin
            m_tr <= 0;
         end
         if (m_tr) begin
            m_cyc <= 0; m_slot <= 0; m_frm <= 0; m_p1 <= 0;
         end else if (m_cyc == SLOT - 1) begin
            m_cyc <= 0;
            if (m_slot == SLOTS - 1) begin
               int nx;
               m_slot <= 0;
               nx = (m_frm >= period_of(m_fast) - 1) ? 0 : m_frm + 1;
               m_frm <= nx;
               m_p1 <= m_en && (nx >= period_of(m_fast) / 2);
            end else begin
               m_slot <= m_slot + 1;
            end
         end else begin
            m_cyc <= m_cyc + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on && !done) begin
         chk((m_slot < NDIG) ? "R2 digit_en" : "R3 blank digit_en",
             int'(digit_en), exp_digits(m_slot));
         chk(m_en ? "R6 phase" : "R7 phase held", int'(cfg_rd[3]), int'(m_p1));
         chk("R5 blink_out", int'(blink_out), int'(!m_p1));
         chk("R9 cfg enable/fast", int'(cfg_rd[1:0]), int'({m_fast, m_en}));
         chk("R10 restart reads 0", int'(cfg_rd[2]), 0);
      end
   end

   task automatic write_ctl(input bit en, input bit f, input bit rs);
      @(posedge clk); #1;
      wr_blink_en = en; wr_fast = f; wr_restart = rs; cs_n = 1'b0;
      @(posedge clk); #1;
      cs_n = 1'b1;
      @(posedge clk);
      @(posedge clk); #1;
   endtask

   task automatic run_len(input bit want_blink, output int n);
      n = 0;
      while (blink_out == want_blink && n < 5000) begin
         n++;
         @(posedge clk); #1;
      end
   endtask

   initial begin
      int n;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset digit_en", int'(digit_en), 1);
      chk("R1 reset blink_out", int'(blink_out), 1);
      chk("R1 reset cfg_rd", int'(cfg_rd), 0);
      chk_on = 1'b1;

      // R10/R2/R3: restart then measure slot runs
      write_ctl(1'b1, 1'b1, 1'b1);
      n = 0;
      while (digit_en == 1 && n < 100) begin n++; @(posedge clk); #1; end
      chk("R2 digit 0 run", n, SLOT);
      while (digit_en != 0) begin @(posedge clk); #1; end
      n = 0;
      while (digit_en == 0 && n < 100) begin n++; @(posedge clk); #1; end
      chk("R3 blank run", n, (SLOTS - NDIG) * SLOT);

      // R6/R10: fast period halves after restart
      write_ctl(1'b1, 1'b1, 1'b1);
      run_len(1'b1, n);
      chk("R6 fast P0 length", n, FASTF / 2 * FRAME);
      run_len(1'b0, n);
      chk("R6 fast P1 length", n, FASTF / 2 * FRAME);

      // R6 slow
      write_ctl(1'b1, 1'b0, 1'b1);
      run_len(1'b1, n);
      chk("R6 slow P0 length", n, SLOWF / 2 * FRAME);
      run_len(1'b0, n);
      chk("R6 slow P1 length", n, SLOWF / 2 * FRAME);

      // R7: disabled blink stays high over a full slow period
      write_ctl(1'b0, 1'b0, 1'b0);
      repeat (FRAME + 1) @(posedge clk);
      #1;
      run_len(1'b1, n);
      chk("R7 blink held high", n, 5000);

      // R6: slow count past fast end, then switch to fast
      write_ctl(1'b1, 1'b0, 1'b1);
      repeat (3 * FASTF / 2 * FRAME + 3) @(posedge clk);
      write_ctl(1'b1, 1'b1, 1'b0);
      repeat (3 * FRAME) @(posedge clk);

      // Random mix of writes and spurious data toggles (R9)
      for (int it = 0; it < 400; it++) begin
         int idle;
         idle = $urandom_range(1, 60);
         for (int k = 0; k < idle; k++) begin
            @(posedge clk); #1;
            if ($urandom_range(0, 3) == 0) begin
               wr_blink_en = 1'($urandom);
               wr_fast     = 1'($urandom);
               wr_restart  = 1'($urandom);
            end
         end
         write_ctl(1'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0));
      end
      repeat (2 * SLOWF * FRAME) @(posedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule